// File: doc/BRIEF.md
# Power Zone Phase Shedding Controller

This block decides how many phases of a multiphase buck regulator switch at any moment. It turns a three-level power-saving request into one of five power zones, numbered 0 to 4. Zone 0 runs every detected phase. Zones 1 to 3 run progressively fewer phases. Zone 4 runs a single phase in discontinuous mode at a reduced switching rate. The block then converts that zone and the detected phase count into a registered per-phase PWM enable mask.

With the request at its highest level, all phases always run. At the middle level, the digitised total-load-current sample is compared once per sample period against four shedding thresholds, and the lightest zone that the load allows is chosen. At the lowest level, a fixed zone is used. One fixed setting applies during boot and another during normal use. The normal setting takes over only after the request has been away from the low level at least once since enable.

The request level is captured when the regulator is enabled, and it stays frozen until the output first reaches regulation. Load-driven shedding also waits for that point. Outputs change only on the enable edge and on sample-period boundaries.

Top module: `zone_shed_ctrl`

## Requirements
- R1: While reset is held, or while `en` is low, `zone` is 0, `dcm_mode` is 0 and `phase_en` is all zeros.
- R2: With `mode_req` at 2'b10 or 2'b11 (high), the zone is 0 and `phase_en` has one bit set for each detected phase, starting from bit 0.
- R3: With `mode_req` at 2'b01 (mid), once regulation has been reached, the zone is chosen from the load sample using strict greater-than comparisons. Above `shed_th4` gives zone 0. Otherwise above `shed_th3` gives zone 1. Otherwise above `shed_th2` gives zone 2. Otherwise above `shed_th1` gives zone 3. Otherwise the zone is 4.
- R4: A threshold whose value is all ones is disabled and skipped in the R3 comparison. With all four thresholds disabled, mid mode gives zone 4.
- R5: The request level is captured at the rising edge of `en`, and later changes are ignored until `reg_ok` has been seen high since enable. Mid mode selects zone 0 until that point.
- R6: With `mode_req` at 2'b00 (low), the zone is `boot_zone` until the effective request has been non-low at least once since enable, and `norm_zone` afterwards. A setting above 4 is treated as 4.
- R7: A zone that the phase count cannot support falls back to zone 0. Counts of 7, 5 and 3 drop zones 1 and 2. Counts of 6 and 4 drop zone 1. Counts of 2 and 1 drop zones 1, 2 and 3.
- R8: The mask pattern depends on the zone. Zone 0 enables every detected phase. Zone 1 enables bits 0, 2, 4 and 6. Zone 2 enables bits 0 and 4. Zones 3 and 4 enable bit 0. The result is always ANDed with the detected-phase mask (bits below the count). A count of 0 is treated as 1, and a count above 8 as 8.
- R9: `dcm_mode` is high exactly when the applied zone is 4.
- R10: The zone, mask and mode flag are registered. They are loaded on the first clock with `en` high and then only once every `SAMPLE_CYCLES` clocks, on the clock at which `SAMPLE_CYCLES-1` clocks have elapsed since the previous load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Regulator enable |
| reg_ok | input | 1 | Output has reached its nominal level |
| mode_req | input | 2 | Power-saving request: 00 low, 01 mid, 1x high |
| phase_cnt | input | 4 | Number of detected phases |
| load_sample | input | 8 | Digitised total load current |
| shed_th1 | input | 8 | Lowest shedding threshold |
| shed_th2 | input | 8 | Second shedding threshold |
| shed_th3 | input | 8 | Third shedding threshold |
| shed_th4 | input | 8 | Highest shedding threshold |
| boot_zone | input | 3 | Fixed zone used in low mode during boot |
| norm_zone | input | 3 | Fixed zone used in low mode after re-arming |
| zone | output | 3 | Applied power zone |
| dcm_mode | output | 1 | Discontinuous, reduced-rate operation |
| phase_en | output | 8 | Per-phase PWM enable mask |

## Verification
A vector table drives mid mode with load samples just above, exactly at, and between the thresholds. This separates strict from inclusive comparison and checks every zone band. The same table sweeps phase counts of 8 down to 1, so zone fallback and mask clipping are told apart for each count, and high mode is tried with two counts and both high encodings. Directed sequences toggle the request before and after `reg_ok`, which separates the boot and normal fixed settings and shows that early request changes are ignored. A load change placed just after a sample boundary shows the outputs holding until the next boundary. Further directed cases cover disabled thresholds and out-of-range phase counts.

// File: rtl/zs_pkg.sv
package zs_pkg;

    localparam int ZONE_W   = 3;
    localparam int ZONE_TOP = 4;

    typedef logic [ZONE_W-1:0] zone_t;

    typedef enum logic [1:0] {
        REQ_LOW  = 2'b00,
        REQ_MID  = 2'b01,
        REQ_HIGH = 2'b10
    } req_t;

    // Both encodings with the upper bit set mean "all phases".
    function automatic req_t decode_req(input logic [1:0] raw);
        if (raw[1])
            return REQ_HIGH;
        else if (raw[0])
            return REQ_MID;
        else
            return REQ_LOW;
    endfunction

    function automatic zone_t clamp_zone(input zone_t z);
        return (z > zone_t'(ZONE_TOP)) ? zone_t'(ZONE_TOP) : z;
    endfunction

endpackage

// File: rtl/zs_sample_timer.sv
module zs_sample_timer #(
    parameter int SAMPLE_CYCLES = 2000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (SAMPLE_CYCLES > 1) ? $clog2(SAMPLE_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(SAMPLE_CYCLES - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = run && (cnt_q == LAST);
        cnt_d = cnt_q;
        if (!run)
            cnt_d = '0;
        else if (cnt_q == LAST)
            cnt_d = '0;
        else
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

endmodule

// File: rtl/zs_load_zone.sv
module zs_load_zone
    import zs_pkg::*;
#(
    parameter int CUR_W = 8,
    parameter int N_TH  = 4
) (
    input  logic [CUR_W-1:0]            sample,
    input  logic [N_TH-1:0][CUR_W-1:0]  th,
    output zone_t                       zone_out
);
    logic [N_TH-1:0] above;

    // A threshold of all ones is switched off and never counts as exceeded.
    for (genvar i = 0; i < N_TH; i++) begin : g_cmp
        assign above[i] = (th[i] != {CUR_W{1'b1}}) && (sample > th[i]);
    end

    // Highest threshold wins: exceeding threshold k (0-based) gives zone N_TH-1-k.
    always_comb begin
        zone_out = zone_t'(N_TH);
        for (int k = 0; k < N_TH; k++) begin
            if (above[k])
                zone_out = zone_t'(N_TH - 1 - k);
        end
    end

endmodule

// File: rtl/zs_zone_mask.sv
module zs_zone_mask
    import zs_pkg::*;
#(
    parameter int NUM_PH = 8,
    parameter int PC_W   = $clog2(NUM_PH + 1)
) (
    input  zone_t              zone_req,
    input  logic [PC_W-1:0]    phase_cnt,
    output zone_t              zone_out,
    output logic [NUM_PH-1:0]  mask_out
);
    logic [PC_W-1:0]   n_cl;
    int                n_i;
    logic [NUM_PH-1:0] det_mask;
    logic [NUM_PH-1:0] pat_half;
    logic [NUM_PH-1:0] pat_quarter;
    logic [NUM_PH-1:0] pat_single;
    logic              ok_z1, ok_z2, ok_z3;

    always_comb begin
        if (phase_cnt == '0)
            n_cl = PC_W'(1);
        else if (32'(phase_cnt) > NUM_PH)
            n_cl = PC_W'(NUM_PH);
        else
            n_cl = phase_cnt;
        n_i = 32'(n_cl);
    end

    for (genvar i = 0; i < NUM_PH; i++) begin : g_pat
        assign det_mask[i]    = (i < n_i);
        assign pat_half[i]    = ((i % 2) == 0);
        assign pat_quarter[i] = ((i % 4) == 0);
        assign pat_single[i]  = (i == 0);
    end

    // Zone support by phase count.
    always_comb begin
        ok_z1 = ((n_i % 4) == 0) && (n_i > 4);
        ok_z2 = ((n_i % 2) == 0) && (n_i >= 4);
        ok_z3 = (n_i >= 3);
        zone_out = zone_req;
        case (zone_req)
            zone_t'(1): if (!ok_z1) zone_out = '0;
            zone_t'(2): if (!ok_z2) zone_out = '0;
            zone_t'(3): if (!ok_z3) zone_out = '0;
            default:    zone_out = zone_req;
        endcase
    end

    always_comb begin
        case (zone_out)
            zone_t'(0): mask_out = det_mask;
            zone_t'(1): mask_out = det_mask & pat_half;
            zone_t'(2): mask_out = det_mask & pat_quarter;
            default:    mask_out = det_mask & pat_single;
        endcase
    end

endmodule

// File: rtl/zone_shed_ctrl.sv
module zone_shed_ctrl
    import zs_pkg::*;
#(
    parameter int NUM_PH        = 8,
    parameter int CUR_W         = 8,
    parameter int SAMPLE_CYCLES = 2000000,
    parameter int PC_W          = $clog2(NUM_PH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic               reg_ok,
    input  logic [1:0]         mode_req,
    input  logic [PC_W-1:0]    phase_cnt,
    input  logic [CUR_W-1:0]   load_sample,
    input  logic [CUR_W-1:0]   shed_th1,
    input  logic [CUR_W-1:0]   shed_th2,
    input  logic [CUR_W-1:0]   shed_th3,
    input  logic [CUR_W-1:0]   shed_th4,
    input  logic [ZONE_W-1:0]  boot_zone,
    input  logic [ZONE_W-1:0]  norm_zone,
    output logic [ZONE_W-1:0]  zone,
    output logic               dcm_mode,
    output logic [NUM_PH-1:0]  phase_en
);
    typedef struct packed {
        logic              en;
        logic              reg_done;
        logic [1:0]        cap_req;
        logic              armed;
        zone_t             zone;
        logic              dcm;
        logic [NUM_PH-1:0] mask;
    } st_t;

    st_t st_d, st_q;

    logic              tick;
    logic              start;
    req_t              live_req;
    req_t              eff_req;
    zone_t             load_zone;
    zone_t             tgt_zone;
    zone_t             map_zone;
    logic [NUM_PH-1:0] map_mask;

    zs_sample_timer #(
        .SAMPLE_CYCLES(SAMPLE_CYCLES)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (en),
        .tick  (tick)
    );

    zs_load_zone #(
        .CUR_W(CUR_W),
        .N_TH (4)
    ) u_cmp (
        .sample   (load_sample),
        .th       ({shed_th4, shed_th3, shed_th2, shed_th1}),
        .zone_out (load_zone)
    );

    zs_zone_mask #(
        .NUM_PH(NUM_PH),
        .PC_W  (PC_W)
    ) u_map (
        .zone_req  (tgt_zone),
        .phase_cnt (phase_cnt),
        .zone_out  (map_zone),
        .mask_out  (map_mask)
    );

    always_comb begin
        start    = en && !st_q.en;
        live_req = decode_req(mode_req);
        // Request is frozen from enable until regulation is first reached.
        eff_req  = (start || st_q.reg_done) ? live_req : decode_req(st_q.cap_req);

        case (eff_req)
            REQ_HIGH: tgt_zone = '0;
            REQ_MID:  tgt_zone = st_q.reg_done ? load_zone : zone_t'(0);
            default:  tgt_zone = st_q.armed ? clamp_zone(norm_zone)
                                            : clamp_zone(boot_zone);
        endcase

        st_d    = st_q;
        st_d.en = en;
        if (!en) begin
            st_d = '0;
        end else begin
            if (start)
                st_d.cap_req = mode_req;
            st_d.reg_done = st_q.reg_done || reg_ok;
            st_d.armed    = st_q.armed || (eff_req != REQ_LOW);
            if (start || tick) begin
                st_d.zone = map_zone;
                st_d.dcm  = (map_zone == zone_t'(ZONE_TOP));
                st_d.mask = map_mask;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign zone     = st_q.zone;
    assign dcm_mode = st_q.dcm;
    assign phase_en = st_q.mask;

endmodule

// File: rtl/zs_shed_checker.sv
module zs_shed_checker #(
    parameter int NUM_PH        = 8,
    parameter int SAMPLE_CYCLES = 2000000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en,
    input logic [2:0]        zone,
    input logic              dcm_mode,
    input logic [NUM_PH-1:0] phase_en
);
    localparam int CW = $clog2(SAMPLE_CYCLES + 1);

    logic [CW-1:0] chk_cnt;
    logic          en_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chk_cnt <= '0;
            en_prev <= 1'b0;
        end else begin
            en_prev <= en;
            if (!en || chk_cnt == CW'(SAMPLE_CYCLES - 1))
                chk_cnt <= '0;
            else
                chk_cnt <= chk_cnt + 1'b1;
        end
    end

    assert_off_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (zone == 3'd0 && phase_en == '0 && !dcm_mode));

    assert_zone_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        zone <= 3'd4);

    assert_half_pattern_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (zone == 3'd1) |-> (phase_en[0] && !phase_en[1]));

    assert_dcm_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        dcm_mode |-> ($countones(phase_en) <= 1));

    assert_hold_between_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (en && en_prev && chk_cnt != CW'(SAMPLE_CYCLES - 1))
            |=> ($stable(zone) && $stable(phase_en) && $stable(dcm_mode)));

endmodule

bind zone_shed_ctrl zs_shed_checker #(
    .NUM_PH       (NUM_PH),
    .SAMPLE_CYCLES(SAMPLE_CYCLES)
) u_shed_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .zone     (zone),
    .dcm_mode (dcm_mode),
    .phase_en (phase_en)
);

// File: tb/tb_zone_shed_ctrl.sv
module tb_zone_shed_ctrl;
    localparam int S = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic       reg_ok = 1'b0;
    logic [1:0] mode_req = 2'b01;
    logic [3:0] phase_cnt = 4'd8;
    logic [7:0] load_sample = 8'd0;
    logic [7:0] th1 = 8'd40, th2 = 8'd80, th3 = 8'd120, th4 = 8'd160;
    logic [2:0] boot_zone = 3'd2, norm_zone = 3'd3;
    logic [2:0] zone;
    logic       dcm_mode;
    logic [7:0] phase_en;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    int ph = 0;

    always #2.5 clk = ~clk;

    zone_shed_ctrl #(.SAMPLE_CYCLES(S)) dut (
        .clk(clk), .rst_n(rst_n), .en(en), .reg_ok(reg_ok),
        .mode_req(mode_req), .phase_cnt(phase_cnt), .load_sample(load_sample),
        .shed_th1(th1), .shed_th2(th2), .shed_th3(th3), .shed_th4(th4),
        .boot_zone(boot_zone), .norm_zone(norm_zone),
        .zone(zone), .dcm_mode(dcm_mode), .phase_en(phase_en)
    );

    // Position within the sample period, counted from the enable edge (R10).
    always @(posedge clk) begin
        if (!rst_n || !en) ph <= 0;
        else ph <= (ph == S - 1) ? 0 : ph + 1;
    end

    // mode, phase count, load, expected zone, expected mask (thresholds 40/80/120/160)
    localparam logic [24:0] VEC [16] = '{
        {2'b01, 4'd8, 8'd200, 3'd0, 8'hFF},
        {2'b01, 4'd8, 8'd150, 3'd1, 8'h55},
        {2'b01, 4'd8, 8'd100, 3'd2, 8'h11},
        {2'b01, 4'd8, 8'd60,  3'd3, 8'h01},
        {2'b01, 4'd8, 8'd10,  3'd4, 8'h01},
        {2'b01, 4'd8, 8'd160, 3'd1, 8'h55},
        {2'b01, 4'd8, 8'd40,  3'd4, 8'h01},
        {2'b01, 4'd7, 8'd100, 3'd0, 8'h7F},
        {2'b01, 4'd6, 8'd100, 3'd2, 8'h11},
        {2'b01, 4'd6, 8'd150, 3'd0, 8'h3F},
        {2'b01, 4'd4, 8'd100, 3'd2, 8'h01},
        {2'b01, 4'd5, 8'd60,  3'd3, 8'h01},
        {2'b01, 4'd2, 8'd60,  3'd0, 8'h03},
        {2'b01, 4'd1, 8'd10,  3'd4, 8'h01},
        {2'b10, 4'd8, 8'd10,  3'd0, 8'hFF},
        {2'b11, 4'd3, 8'd10,  3'd0, 8'h07}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_out(input string req, input logic [2:0] ez, input logic [7:0] em);
        chk(req, {21'd0, zone, dcm_mode, phase_en}, {21'd0, ez, (ez == 3'd4), em});
    endtask

    task automatic settle();
        repeat (S + 1) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk_out("R1 reset state", 3'd0, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);

        // R5: request frozen at enable (mid) until reg_ok
        mode_req = 2'b01; load_sample = 8'd10; en = 1'b1;
        settle();
        chk_out("R5 mid before regulation gives zone 0", 3'd0, 8'hFF);
        mode_req = 2'b00;
        settle();
        chk_out("R5 low request ignored before reg_ok", 3'd0, 8'hFF);
        reg_ok = 1'b1;
        settle();
        chk_out("R6 low after non-low start uses normal setting", 3'd3, 8'h01);

        // R1 / R6: disable, then boot in low mode
        en = 1'b0; reg_ok = 1'b0;
        repeat (2) @(negedge clk);
        chk_out("R1 disabled outputs clear", 3'd0, 8'h00);
        en = 1'b1;
        settle();
        chk_out("R6 boot setting in low mode", 3'd2, 8'h11);
        reg_ok = 1'b1;
        settle();
        chk_out("R6 boot setting kept until re-armed", 3'd2, 8'h11);
        mode_req = 2'b01; load_sample = 8'd200;
        settle();
        chk_out("R3 mid after regulation heavy load", 3'd0, 8'hFF);
        mode_req = 2'b00;
        settle();
        chk_out("R6 normal setting after re-entering low", 3'd3, 8'h01);
        norm_zone = 3'd7;
        settle();
        chk_out("R6 R9 setting above 4 clamps to zone 4", 3'd4, 8'h01);
        norm_zone = 3'd3;

        // Main table: R2 R3 R7 R8 R9
        for (int i = 0; i < 16; i++) begin
            mode_req    = VEC[i][24:23];
            phase_cnt   = VEC[i][22:19];
            load_sample = VEC[i][18:11];
            settle();
            chk_out($sformatf("R2 R3 R7 R8 R9 vector %0d", i), VEC[i][10:8], VEC[i][7:0]);
        end

        // R4: disabled thresholds
        mode_req = 2'b01; phase_cnt = 4'd8; load_sample = 8'd250; th4 = 8'hFF;
        settle();
        chk_out("R4 top threshold skipped", 3'd1, 8'h55);
        th1 = 8'hFF; th2 = 8'hFF; th3 = 8'hFF;
        settle();
        chk_out("R4 all thresholds skipped", 3'd4, 8'h01);
        th1 = 8'd40; th2 = 8'd80; th3 = 8'd120; th4 = 8'd160;

        // R10: change just after a boundary holds until the next one
        load_sample = 8'd200;
        settle();
        while (ph != 0) @(negedge clk);
        load_sample = 8'd10;
        while (ph != S - 1) @(negedge clk);
        chk_out("R10 held until sample boundary", 3'd0, 8'hFF);
        @(negedge clk);
        chk_out("R10 applied at sample boundary", 3'd4, 8'h01);

        // R2 / R10: high mode loaded on the enable edge
        en = 1'b0; reg_ok = 1'b0; mode_req = 2'b10; phase_cnt = 4'd5;
        repeat (2) @(negedge clk);
        en = 1'b1;
        @(negedge clk);
        chk_out("R2 R10 high mode loaded at enable", 3'd0, 8'h1F);

        // R8: out-of-range phase counts
        phase_cnt = 4'd0;
        settle();
        chk_out("R8 count 0 treated as 1", 3'd0, 8'h01);
        phase_cnt = 4'd12;
        settle();
        chk_out("R8 count above 8 treated as 8", 3'd0, 8'hFF);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule